// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Nesting Controller

This block is the processor-facing half of an interrupt controller. Software reads an acknowledge register to claim the best pending source. It writes a completion register, carrying a 10-bit source ID, when the handler finishes. The block keeps the ID that is currently in service and reports that ID's priority. It decides whether a new acknowledge may preempt the interrupt in service, and it emits one-cycle strobes that clear or re-set the per-source pending bits held elsewhere.

Nested preemption is recorded as a linked list. Each source has a link register that holds the ID that was in service when that source was acknowledged. Completing the interrupt in service pops the list. Completing an interrupt that sits lower in the list removes it from the middle. This removal is done by a small walker that follows one link per clock cycle, and `busy` is held high while the walk runs. ID 1023 means "none" throughout the block.

Top module: `nest_ctrl`

## Requirements
- R1: An acknowledge read returns 1023, raises no clear strobe and leaves the in-service ID unchanged in either of two cases: `hp_id` is 1023, or the priority of `hp_id` is equal to or numerically above `run_prio`.
- R2: Any other acknowledge returns `hp_id` on `bus_rdata` and makes `hp_id` the in-service ID. The same edge raises `pend_clr` for one cycle, with only bit `hp_id` set, and records the former in-service ID as the link of `hp_id`.
- R3: `run_prio` is the 8-bit priority of `run_id` with a zero ninth bit. It follows the priority input combinationally, and it is 0x100 while `run_id` is 1023.
- R4: A completion write has no effect while `run_id` is 1023. No strobe is raised and `run_id` stays 1023.
- R5: A completion for source n raises bit n of `pend_set` for one cycle when the block is not idle and all three of these hold: source n is level-sensitive (`src_edge[n]`=0), it is enabled (`src_en[n]`=1), and its line is high (`src_level[n]`=1). Any other combination raises no bit.
- R6: A completion whose ID equals `run_id` makes `run_id` equal to the stored link of that ID on the same edge, so the list is popped.
- R7: A completion for a different ID leaves `run_id` unchanged. It removes that ID from the list: the entry that linked to it now links to what it linked to. An ID that is not in the list changes nothing.
- R8: After reset, `run_id` is 1023, `run_prio` is 0x100, `busy` is 0, all links are 1023 and no strobe or read response is active.
- R9: The list walk starts on the edge after a mid-list completion and makes one hop per cycle. `busy` is high for exactly as many cycles as links visited, and a bus request made while `busy` is high is ignored: no response, no strobe, no change of state.
- R10: A read at offset 0x0C is the acknowledge. A write at offset 0x10 is the completion, with the ID in `bus_wdata`. A read at any other offset returns 0 with no effect, and a write at any other offset is ignored. Read data and `bus_rvalid` appear one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 10 | Write data (completion ID) |
| bus_rvalid | output | 1 | Read response valid, one cycle |
| bus_rdata | output | 10 | Read response data |
| busy | output | 1 | List walk in progress; accesses ignored |
| hp_id | input | 10 | Highest-pending source ID, 1023 if none |
| src_prio | input | 8*NUM_SRC | Per-source priority, source n in bits [8n+7:8n] |
| src_edge | input | NUM_SRC | 1 = edge-triggered source |
| src_en | input | NUM_SRC | Source enable |
| src_level | input | NUM_SRC | Current source line level |
| pend_clr | output | NUM_SRC | One-cycle pending-clear strobe |
| pend_set | output | NUM_SRC | One-cycle pending-set strobe |
| run_id | output | 10 | In-service source ID, 1023 if none |
| run_prio | output | 9 | Running priority, 0x100 if idle |

## Verification
The acknowledge result, `pend_clr`, `pend_set` and the new `run_id` are registered on the edge that takes the request. The bench drives each request on a falling edge and samples all of these results on the next falling edge. `run_prio` is combinational, so it is checked in the same half-cycle in which the bench changes a priority. A mid-list completion keeps `busy` high for one cycle per link visited. The bench counts those cycles against the hop count of its own list model before it checks `run_id`, and it places an ignored acknowledge inside that window.

// File: rtl/nest_pkg.sv
package nest_pkg;
    localparam int ID_W    = 10;
    localparam int PRIO_W  = 8;
    localparam int RPRIO_W = PRIO_W + 1;
    localparam int ADDR_W  = 8;

    typedef logic [ID_W-1:0] irq_id_t;

    localparam irq_id_t            NO_ID     = irq_id_t'(10'h3FF);
    localparam logic [RPRIO_W-1:0] IDLE_PRIO = 9'h100;

    // software-visible offsets of the two decoded registers
    localparam logic [ADDR_W-1:0] OFS_ACK = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_EOI = 8'h10;

    typedef struct packed {
        logic    ack;       // acknowledge read accepted
        logic    eoi;       // completion write accepted
        logic    other_rd;  // read of an undecoded offset
        irq_id_t id;        // completion ID
    } bus_cmd_t;
endpackage

// File: rtl/nest_bus_decode.sv
module nest_bus_decode
    import nest_pkg::*;
(
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  irq_id_t           bus_wdata,
    input  logic              busy,
    output bus_cmd_t          cmd
);
    logic live;
    assign live = bus_req && !busy;

    always_comb begin
        cmd          = '0;
        cmd.ack      = live && !bus_we && (bus_addr == OFS_ACK);
        cmd.other_rd = live && !bus_we && (bus_addr != OFS_ACK);
        cmd.eoi      = live &&  bus_we && (bus_addr == OFS_EOI);
        cmd.id       = bus_wdata;
    end
endmodule

// File: rtl/nest_link_store.sv
module nest_link_store
    import nest_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  irq_id_t wr_idx,
    input  irq_id_t wr_data,
    input  irq_id_t ra_idx,
    output irq_id_t ra_data,
    input  irq_id_t rb_idx,
    output irq_id_t rb_data
);
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    irq_id_t link_q [NUM_SRC];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SRC; i++) link_q[i] <= NO_ID;
        end else if (wr_en && (wr_idx < ID_W'(NUM_SRC))) begin
            link_q[wr_idx[SRC_W-1:0]] <= wr_data;
        end
    end

    // out-of-range reads see the terminator
    assign ra_data = (ra_idx < ID_W'(NUM_SRC)) ? link_q[ra_idx[SRC_W-1:0]] : NO_ID;
    assign rb_data = (rb_idx < ID_W'(NUM_SRC)) ? link_q[rb_idx[SRC_W-1:0]] : NO_ID;
endmodule

// File: rtl/nest_walker.sv
module nest_walker
    import nest_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  irq_id_t start_cur,
    input  irq_id_t start_tgt,
    input  irq_id_t link_cur,   // link of cur
    input  irq_id_t link_tgt,   // link of tgt
    output logic    busy,
    output irq_id_t cur,
    output irq_id_t tgt,
    output logic    wr_en,
    output irq_id_t wr_idx,
    output irq_id_t wr_data
);
    logic hit, stop;

    assign hit  = (link_cur != NO_ID) && (link_cur == tgt);
    assign stop = (link_cur == NO_ID) || hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cur  <= NO_ID;
            tgt  <= NO_ID;
        end else if (start) begin
            busy <= 1'b1;
            cur  <= start_cur;
            tgt  <= start_tgt;
        end else if (busy) begin
            if (stop) busy <= 1'b0;
            else      cur  <= link_cur;
        end
    end

    // splice: the entry pointing at tgt now points past it
    assign wr_en   = busy && hit;
    assign wr_idx  = cur;
    assign wr_data = link_tgt;
endmodule

// File: rtl/nest_ctrl.sv
module nest_ctrl
    import nest_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_req,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [ID_W-1:0]           bus_wdata,
    output logic                      bus_rvalid,
    output logic [ID_W-1:0]           bus_rdata,
    output logic                      busy,
    input  logic [ID_W-1:0]           hp_id,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input  logic [NUM_SRC-1:0]        src_edge,
    input  logic [NUM_SRC-1:0]        src_en,
    input  logic [NUM_SRC-1:0]        src_level,
    output logic [NUM_SRC-1:0]        pend_clr,
    output logic [NUM_SRC-1:0]        pend_set,
    output logic [ID_W-1:0]           run_id,
    output logic [RPRIO_W-1:0]        run_prio
);
    bus_cmd_t cmd;
    irq_id_t  link_a, link_b, walk_cur, walk_tgt, walk_wr_idx, walk_wr_data;
    logic     walk_wr_en, walk_start;
    logic     st_wr_en;
    irq_id_t  st_wr_idx, st_wr_data;
    logic [RPRIO_W-1:0] hp_prio;
    logic     hp_ok, eoi_live, eoi_repend;

    nest_bus_decode u_dec (
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .busy(busy), .cmd(cmd)
    );

    function automatic logic [RPRIO_W-1:0] prio_sel(input irq_id_t id,
                                                    input logic [NUM_SRC*PRIO_W-1:0] pv);
        logic [RPRIO_W-1:0] r;
        r = IDLE_PRIO;
        for (int i = 0; i < NUM_SRC; i++)
            if (id == ID_W'(i)) r = {1'b0, pv[i*PRIO_W +: PRIO_W]};
        return r;
    endfunction

    function automatic logic [NUM_SRC-1:0] one_hot(input irq_id_t id);
        logic [NUM_SRC-1:0] v;
        for (int i = 0; i < NUM_SRC; i++) v[i] = (id == ID_W'(i));
        return v;
    endfunction

    function automatic logic bit_sel(input irq_id_t id, input logic [NUM_SRC-1:0] v);
        logic r;
        r = 1'b0;
        for (int i = 0; i < NUM_SRC; i++)
            if (id == ID_W'(i)) r = v[i];
        return r;
    endfunction

    always_comb begin
        run_prio   = prio_sel(run_id, src_prio);
        hp_prio    = prio_sel(hp_id, src_prio);
        hp_ok      = (hp_id != NO_ID) && (hp_id < ID_W'(NUM_SRC)) && (hp_prio < run_prio);
        eoi_live   = cmd.eoi && (run_id != NO_ID);
        eoi_repend = eoi_live && !bit_sel(cmd.id, src_edge)
                     && bit_sel(cmd.id, src_en) && bit_sel(cmd.id, src_level);
        walk_start = eoi_live && (cmd.id != run_id);
    end

    // link write: acknowledge records the preempted ID, walker splices
    always_comb begin
        if (cmd.ack && hp_ok) begin
            st_wr_en   = 1'b1;
            st_wr_idx  = hp_id;
            st_wr_data = run_id;
        end else begin
            st_wr_en   = walk_wr_en;
            st_wr_idx  = walk_wr_idx;
            st_wr_data = walk_wr_data;
        end
    end

    nest_link_store #(.NUM_SRC(NUM_SRC)) u_links (
        .clk(clk), .rst(rst),
        .wr_en(st_wr_en), .wr_idx(st_wr_idx), .wr_data(st_wr_data),
        .ra_idx(busy ? walk_cur : run_id), .ra_data(link_a),
        .rb_idx(walk_tgt), .rb_data(link_b)
    );

    nest_walker u_walk (
        .clk(clk), .rst(rst),
        .start(walk_start), .start_cur(run_id), .start_tgt(cmd.id),
        .link_cur(link_a), .link_tgt(link_b),
        .busy(busy), .cur(walk_cur), .tgt(walk_tgt),
        .wr_en(walk_wr_en), .wr_idx(walk_wr_idx), .wr_data(walk_wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_id     <= NO_ID;
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
            pend_clr   <= '0;
            pend_set   <= '0;
        end else begin
            bus_rvalid <= 1'b0;
            pend_clr   <= '0;
            pend_set   <= '0;
            if (cmd.ack) begin
                bus_rvalid <= 1'b1;
                if (hp_ok) begin
                    bus_rdata <= hp_id;
                    run_id    <= hp_id;
                    pend_clr  <= one_hot(hp_id);
                end else begin
                    bus_rdata <= NO_ID;
                end
            end
            if (cmd.other_rd) begin
                bus_rvalid <= 1'b1;
                bus_rdata  <= '0;
            end
            if (eoi_live) begin
                if (eoi_repend)         pend_set <= one_hot(cmd.id);
                if (cmd.id == run_id)   run_id   <= link_a;
            end
        end
    end
endmodule

// File: rtl/nest_ctrl_chk.sv
module nest_ctrl_chk
    import nest_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_req,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_rvalid,
    input logic [ID_W-1:0]     bus_rdata,
    input logic                busy,
    input logic [NUM_SRC-1:0]  pend_clr,
    input logic [NUM_SRC-1:0]  pend_set,
    input logic [ID_W-1:0]     run_id
);
    p_refuse_no_clear_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_rvalid && bus_rdata == NO_ID) |-> (pend_clr == '0));

    p_strobes_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pend_clr) && $onehot0(pend_set));

    p_grant_runs_r2: assert property (@(posedge clk) disable iff (rst)
        (|pend_clr) |-> (bus_rvalid && run_id != NO_ID && bus_rdata == run_id));

    p_idle_eoi_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_addr == OFS_EOI && !busy && run_id == NO_ID)
        |=> (run_id == NO_ID && pend_set == '0 && !busy));

    p_reset_state_r8: assert property (@(posedge clk)
        rst |=> (run_id == NO_ID && !busy && pend_clr == '0 && !bus_rvalid));

    p_walk_holds_run_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(run_id));

    p_busy_ignores_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_req) |=> (!bus_rvalid && pend_clr == '0 && pend_set == '0));
endmodule

bind nest_ctrl nest_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .busy(busy),
    .pend_clr(pend_clr), .pend_set(pend_set), .run_id(run_id)
);

// File: tb/nest_ctrl_tb.sv
module nest_ctrl_tb;
    localparam int N = 8;
    localparam logic [9:0] NONE = 10'h3FF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_req = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [9:0] bus_wdata = '0;
    logic bus_rvalid, busy;
    logic [9:0] bus_rdata, run_id;
    logic [9:0] hp_id = NONE;
    logic [N*8-1:0] src_prio;
    logic [N-1:0] src_edge, src_en, src_level, pend_clr, pend_set;
    logic [8:0] run_prio;

    logic [7:0] prio_a [N];
    logic [N-1:0] edge_v = '1, en_v = '1, lvl_v = '0;

    int n_chk = 0, n_err = 0;
    logic [9:0] m_run = NONE;
    logic [9:0] m_link [N];

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) src_prio[i*8 +: 8] = prio_a[i];
    end
    assign src_edge  = edge_v;
    assign src_en    = en_v;
    assign src_level = lvl_v;

    nest_ctrl #(.NUM_SRC(N)) u_dut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .busy(busy),
        .hp_id(hp_id), .src_prio(src_prio), .src_edge(src_edge), .src_en(src_en),
        .src_level(src_level), .pend_clr(pend_clr), .pend_set(pend_set),
        .run_id(run_id), .run_prio(run_prio)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] m_prio();
        return (m_run == NONE) ? 9'h100 : {1'b0, prio_a[m_run[2:0]]};
    endfunction

    task automatic check_run(input string req);
        check(run_id == m_run, req, 32'(run_id), 32'(m_run));
        check(run_prio == m_prio(), {req, " prio"}, 32'(run_prio), 32'(m_prio()));
    endtask

    // R1 R2 R10: acknowledge read, called on a falling edge
    task automatic do_ack(input string req);
        logic ok;
        logic [9:0] e_data;
        logic [N-1:0] e_clr;
        ok = (hp_id != NONE) && (hp_id < N) && ({1'b0, prio_a[hp_id[2:0]]} < m_prio());
        e_data = ok ? hp_id : NONE;
        e_clr  = ok ? (N'(1) << hp_id) : '0;
        if (ok) begin
            m_link[hp_id[2:0]] = m_run;
            m_run = hp_id;
        end
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 8'h0C;
        @(negedge clk);
        bus_req = 1'b0;
        check(bus_rvalid == 1'b1, {req, " rvalid"}, 32'(bus_rvalid), 1);
        check(bus_rdata == e_data, {req, " data"}, 32'(bus_rdata), 32'(e_data));
        check(pend_clr == e_clr, {req, " clr"}, 32'(pend_clr), 32'(e_clr));
        check_run(req);
    endtask

    // list model walk; returns hop count
    function automatic int m_eoi(input logic [9:0] id);
        logic [9:0] cur, nx;
        int hops;
        hops = 0;
        if (m_run == NONE) return 0;
        if (id == m_run) begin
            m_run = m_link[m_run[2:0]];
            return 0;
        end
        cur = m_run;
        forever begin
            hops++;
            nx = m_link[cur[2:0]];
            if (nx == NONE) break;
            if (nx == id) begin
                m_link[cur[2:0]] = (id < N) ? m_link[id[2:0]] : NONE;
                break;
            end
            cur = nx;
        end
        return hops;
    endfunction

    // R4 R5 R6 R7 R9: completion write, called on a falling edge
    task automatic do_eoi(input logic [9:0] id, input string req);
        logic [N-1:0] e_set;
        int hops, cnt;
        e_set = '0;
        if (m_run != NONE && id < N && !edge_v[id[2:0]] && en_v[id[2:0]] && lvl_v[id[2:0]])
            e_set = N'(1) << id;
        hops = m_eoi(id);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'h10; bus_wdata = id;
        @(negedge clk);
        bus_req = 1'b0;
        check(pend_set == e_set, {req, " set (R5)"}, 32'(pend_set), 32'(e_set));
        cnt = 0;
        while (busy && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == hops, {req, " busy cycles (R9)"}, 32'(cnt), 32'(hops));
        check_run(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin prio_a[i] = 8'h80; m_link[i] = NONE; end
        repeat (3) @(negedge clk);
        // R8 reset state
        check(run_id == NONE, "R8 run_id", 32'(run_id), 32'(NONE));
        check(run_prio == 9'h100, "R8 run_prio", 32'(run_prio), 32'h100);
        check(!busy && !bus_rvalid && pend_clr == '0 && pend_set == '0, "R8 idle outputs",
              {busy, bus_rvalid, 30'(pend_clr)}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1: nothing pending
        hp_id = NONE;
        do_ack("R1 none pending");

        // R2 R6: each source alone
        for (int s = 0; s < N; s++) begin
            prio_a[s] = 8'(s * 16 + 1);
            hp_id = 10'(s);
            do_ack("R2 single grant");
            do_eoi(10'(s), "R6 single pop");
        end

        // R1 R2: priority comparison sweep, src1 running, src2 contending
        for (int pa = 0; pa < 16; pa++) begin
            for (int pb = 0; pb < 16; pb++) begin
                prio_a[1] = 8'(pa * 17);
                prio_a[2] = 8'(pb * 17);
                hp_id = 10'd1;
                do_ack("R2 first grant");
                hp_id = 10'd2;
                do_ack("R1 preempt strictly below");
                if (m_run == 10'd2) do_eoi(10'd2, "R6 pop preemptor");
                do_eoi(10'd1, "R6 pop base");
            end
        end

        // R3: running priority follows live input
        prio_a[3] = 8'h50; hp_id = 10'd3;
        do_ack("R3 grant");
        for (int v = 0; v < 256; v += 37) begin
            prio_a[3] = 8'(v);
            #1;
            check(run_prio == 9'(v), "R3 live prio", 32'(run_prio), 32'(v));
        end
        @(negedge clk);

        // R10: undecoded read and write
        hp_id = 10'd4; prio_a[4] = 8'h00;
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 8'h14;
        @(negedge clk);
        bus_req = 1'b0;
        check(bus_rvalid && bus_rdata == 10'd0 && pend_clr == '0, "R10 other read",
              {bus_rvalid, 21'd0, bus_rdata}, 32'h8000_0000);
        check_run("R10 other read run");
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'h14; bus_wdata = 10'd3;
        @(negedge clk);
        bus_req = 1'b0;
        check(!bus_rvalid && pend_set == '0 && !busy, "R10 other write", 32'(pend_set), 0);
        check_run("R10 other write run");
        do_eoi(10'd3, "R6 pop after decode");

        // R4 R5: all source-mode combinations on source 5
        prio_a[5] = 8'h10; hp_id = 10'd5;
        for (int c = 0; c < 8; c++) begin
            edge_v[5] = c[0]; en_v[5] = c[1]; lvl_v[5] = c[2];
            do_ack("R5 grant");
            do_eoi(10'd5, "R5 repend combo");
        end
        edge_v[5] = 1'b0; en_v[5] = 1'b1; lvl_v[5] = 1'b1;
        do_eoi(10'd5, "R4 idle completion");
        edge_v = '1; lvl_v = '0;

        // R6 R7: nested list, middle and non-member removal
        prio_a[1] = 8'h80; prio_a[2] = 8'h60; prio_a[3] = 8'h40; prio_a[4] = 8'h20;
        for (int s = 1; s <= 4; s++) begin hp_id = 10'(s); do_ack("R2 nest grant"); end
        do_eoi(10'd2, "R7 remove middle");
        do_eoi(10'd7, "R7 non-member");
        do_eoi(NONE, "R7 none id");
        do_eoi(10'd4, "R6 pop top");
        do_eoi(10'd1, "R7 remove bottom");
        do_eoi(10'd3, "R6 pop last");

        // R9: acknowledge during a walk is ignored
        for (int s = 1; s <= 4; s++) begin hp_id = 10'(s); do_ack("R2 nest grant"); end
        begin
            int hops, cnt;
            hops = m_eoi(10'd1);
            bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'h10; bus_wdata = 10'd1;
            @(negedge clk);
            hp_id = 10'd6; prio_a[6] = 8'h00;
            bus_we = 1'b0; bus_addr = 8'h0C;
            @(negedge clk);
            bus_req = 1'b0;
            check(!bus_rvalid && pend_clr == '0, "R9 ack ignored while busy",
                  {bus_rvalid, 31'(pend_clr)}, 0);
            cnt = 1;
            while (busy && cnt < 100) begin cnt++; @(negedge clk); end
            check(cnt == hops, "R9 walk length", 32'(cnt), 32'(hops));
            check_run("R9 run after stalled ack");
        end
        do_eoi(10'd4, "R6 drain");
        do_eoi(10'd3, "R6 drain");
        do_eoi(10'd2, "R6 drain");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule